// File: doc/BRIEF.md
# GPIO Bank Input Debouncer With Shared Period Timers

This block filters the input levels of one GPIO bank of up to 32 pins. Every pin is first passed through a synchronizer. Its debounced level then follows the synchronized level only after that level has held steady for a programmable number of clock cycles. Three period registers set those cycle counts. All pins of the bank share these three timers. Each pin picks a timer, or turns filtering off, with a 2-bit code.

The two bits of a pin's code sit in two separate select registers, at the pin's own bit position. Code zero means no filtering, so the block passes inputs straight through after reset. Pins whose direction input marks them as outputs are never filtered. A simple register port writes and reads the select and period registers, and the filtered levels appear on a parallel output bus. Software-side concerns are left to the surrounding logic: turning times into cycle counts, deciding which pins share a timer, and raising interrupts.

Top module: `gpio_debounce_bank`

## Requirements
- R1: While reset is held and after its release, every debounced output reads 0 and every register reads back 0, so all pins start with code 0.
- R2: Byte addresses on the register port: 0x00 holds the upper code bits, 0x04 holds the lower code bits, and 0x50, 0x54 and 0x58 hold the periods of timers 1, 2 and 3. A period keeps only its low PERIOD_W bits and reads upper bits as 0. Reads of any other address return 0, and writes to them change nothing.
- R3: A pin's code is {upper bit, lower bit} taken at the pin's bit position. With code 0, the debounced output equals the pin input delayed by three clock edges: two synchronizer stages and one output register.
- R4: With a nonzero code c and timer period P, a change on the input appears at the output P+3 edges after it is applied, provided the input holds that long.
- R5: An input pulse on a filtered pin whose synchronized length is P cycles or less leaves the debounced output unchanged.
- R6: A period of 0 together with a nonzero code gives the same three-edge latency as code 0.
- R7: A pin whose direction bit is 1 (output) is not filtered, whatever its code. Its debounced output follows the input with the three-edge latency.
- R8: A write that changes a pin's code, or a write to the period register of the pin's current timer, restarts that pin's count. The count reloads the new period on the edge after the write. The output holds on that edge.
- R9: Pins that share a timer filter independently of each other. Pins on different timers use their own periods at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; periods are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| pin_dir | input | NPINS | Per-pin direction, 1 = output (never filtered) |
| pin_in | input | NPINS | Raw pin levels |
| pin_db | output | NPINS | Debounced pin levels |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a count. A period or code write has to arrive while a pin is partway through counting down a mismatch. The output edge then moves from its original cycle to one set by the new period. The bench creates this case on purpose: it drops one pin, waits until the count is half spent, and rewrites that pin's period. It then checks that the output has not moved at the old deadline but has moved by the new one. A long run follows with sparse random pin toggles, random code, period and direction changes, and a cycle-by-cycle reference model. That run also produces writes that land during a count on other pins.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

  // Two code bits per pin: zero turns filtering off, 1..3 pick a timer.
  localparam int CODE_W  = 2;
  localparam int NTIMERS = (1 << CODE_W) - 1;

  // Byte offsets inside the block's register window.
  localparam int OFS_SEL_HI   = 'h00;
  localparam int OFS_SEL_LO   = 'h04;
  localparam int OFS_PER_BASE = 'h50;
  localparam int OFS_PER_STEP = 4;

  typedef logic [CODE_W-1:0] tcode_t;

  localparam tcode_t CODE_OFF = '0;

  // Byte offset of the period register for timer t (1..NTIMERS).
  function automatic int per_offset(input int t);
    return OFS_PER_BASE + (t - 1) * OFS_PER_STEP;
  endfunction

endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] dout
);

  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [STAGES-1:0][NPINS-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gdb_regs.sv
module gdb_regs
  import gdb_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int PERIOD_W = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output tcode_t [NPINS-1:0]                pin_code,
  output logic [NPINS-1:0][PERIOD_W-1:0]    pin_period,
  output logic [NPINS-1:0]                  pin_restart
);

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_SEL_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFS_SEL_LO);

  logic [NPINS-1:0]                  sel_hi_q, sel_hi_d;
  logic [NPINS-1:0]                  sel_lo_q, sel_lo_d;
  logic [NTIMERS-1:0][PERIOD_W-1:0]  per_q, per_d;
  logic [NPINS-1:0]                  restart_q, restart_d;
  logic [NTIMERS:0]                  per_hit;
  logic                              hi_hit, lo_hit;
  logic                              sel_en, per_en;

  // Address decode of the write strobe.
  always_comb begin
    hi_hit     = wr && (addr == A_HI);
    lo_hit     = wr && (addr == A_LO);
    per_hit[0] = 1'b0;
    for (int t = 1; t <= NTIMERS; t++) begin
      per_hit[t] = wr && (addr == ADDR_W'(per_offset(t)));
    end
    sel_en = hi_hit || lo_hit;
    per_en = |per_hit;
  end

  // Next-state values of the configuration registers.
  always_comb begin
    sel_hi_d = hi_hit ? wdata[NPINS-1:0] : sel_hi_q;
    sel_lo_d = lo_hit ? wdata[NPINS-1:0] : sel_lo_q;
    per_d    = per_q;
    for (int t = 1; t <= NTIMERS; t++) begin
      if (per_hit[t]) begin
        per_d[t-1] = wdata[PERIOD_W-1:0];
      end
    end
  end

  // A pin restarts when its code changes or its own timer is rewritten.
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      restart_d[i] = ({sel_hi_d[i], sel_lo_d[i]} != {sel_hi_q[i], sel_lo_q[i]})
                   || per_hit[{sel_hi_q[i], sel_lo_q[i]}];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_q <= '0;
      sel_lo_q <= '0;
    end else if (sel_en) begin
      sel_hi_q <= sel_hi_d;
      sel_lo_q <= sel_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
    end else if (per_en) begin
      per_q <= per_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= '0;
    end else begin
      restart_q <= restart_d;
    end
  end

  // Per-pin code and selected period.
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pin_code[i] = {sel_hi_q[i], sel_lo_q[i]};
      if (pin_code[i] == CODE_OFF) begin
        pin_period[i] = '0;
      end else begin
        pin_period[i] = per_q[pin_code[i] - tcode_t'(1)];
      end
    end
  end

  assign pin_restart = restart_q;

  // Read multiplexer.
  always_comb begin
    rdata = '0;
    if (addr == A_HI) begin
      rdata[NPINS-1:0] = sel_hi_q;
    end else if (addr == A_LO) begin
      rdata[NPINS-1:0] = sel_lo_q;
    end else begin
      for (int t = 1; t <= NTIMERS; t++) begin
        if (addr == ADDR_W'(per_offset(t))) begin
          rdata[PERIOD_W-1:0] = per_q[t-1];
        end
      end
    end
  end

endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_in,
  input  logic                bypass,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                db_out
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                db_q, db_d;
  logic                cnt_en, db_en;

  always_comb begin
    cnt_d  = cnt_q;
    db_d   = db_q;
    cnt_en = 1'b1;
    db_en  = 1'b0;
    if (bypass) begin
      db_d  = sync_in;
      db_en = 1'b1;
      cnt_d = period;
    end else if (restart || (sync_in == db_q)) begin
      cnt_d = period;
    end else if (cnt_q == '0) begin
      db_d  = sync_in;
      db_en = 1'b1;
      cnt_d = period;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= 1'b0;
    end else if (db_en) begin
      db_q <= db_d;
    end
  end

  assign db_out = db_q;

endmodule

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank
  import gdb_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int PERIOD_W    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_dir,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_db
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0]              rst_pipe_q, rst_pipe_d;
  logic                               rst_n_i;
  logic [NPINS-1:0]                   sync_val;
  tcode_t [NPINS-1:0]                 pin_code;
  logic [NPINS-1:0][PERIOD_W-1:0]     pin_period;
  logic [NPINS-1:0]                   pin_restart;
  logic [NPINS-1:0]                   bypass;

  // Reset asserts at once and leaves after RST_STAGES clock edges.
  always_comb begin
    rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_n_i = rst_pipe_q[RST_STAGES-1];

  gdb_sync #(
    .NPINS  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (pin_in),
    .dout  (sync_val)
  );

  gdb_regs #(
    .NPINS    (NPINS),
    .PERIOD_W (PERIOD_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .pin_code    (pin_code),
    .pin_period  (pin_period),
    .pin_restart (pin_restart)
  );

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      bypass[i] = (pin_code[i] == CODE_OFF) || pin_dir[i];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gdb_pin_filter #(
      .PERIOD_W (PERIOD_W)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .sync_in (sync_val[i]),
      .bypass  (bypass[i]),
      .restart (pin_restart[i]),
      .period  (pin_period[i]),
      .db_out  (pin_db[i])
    );
  end

endmodule

// File: rtl/gpio_debounce_bank_chk.sv
module gpio_debounce_bank_chk
  import gdb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic [NPINS-1:0]  pin_db,
  input logic [NPINS-1:0]  sync_val,
  input logic [NPINS-1:0]  bypass,
  input logic [NPINS-1:0]  pin_restart,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);

  logic addr_mapped;

  always_comb begin
    addr_mapped = (reg_addr == ADDR_W'(OFS_SEL_HI)) || (reg_addr == ADDR_W'(OFS_SEL_LO));
    for (int t = 1; t <= NTIMERS; t++) begin
      if (reg_addr == ADDR_W'(per_offset(t))) begin
        addr_mapped = 1'b1;
      end
    end
  end

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    !addr_mapped |-> (reg_rdata == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    p_bypass_follow_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
      $past(bypass[i]) |-> (pin_db[i] == $past(sync_val[i])));

    p_change_to_input_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
      ($past(!bypass[i]) && (pin_db[i] != $past(pin_db[i]))) |-> (pin_db[i] == $past(sync_val[i])));

    p_hold_when_equal_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
      $past(!bypass[i] && (sync_val[i] == pin_db[i])) |-> (pin_db[i] == $past(pin_db[i])));

    p_restart_holds_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
      $past(!bypass[i] && pin_restart[i]) |-> (pin_db[i] == $past(pin_db[i])));
  end

endmodule

bind gpio_debounce_bank gpio_debounce_bank_chk #(
  .NPINS  (NPINS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n_i     (rst_n_i),
  .pin_db      (pin_db),
  .sync_val    (sync_val),
  .bypass      (bypass),
  .pin_restart (pin_restart),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata)
);

// File: tb/gpio_debounce_bank_test.sv
module gpio_debounce_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 32;
  localparam int PW         = 16;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_dir;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_db;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_debounce_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_dir   (pin_dir),
    .pin_in    (pin_in),
    .pin_db    (pin_db)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    model_on = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference state.
  logic [NP-1:0] m_s1, m_s2, m_db, m_hi, m_lo, m_rst;
  int            m_per [4];
  int            m_cnt [NP];
  logic [NP-1:0] t_db, t_hi, t_lo, t_rst;
  int            t_cnt [NP];
  int            t_c, t_p, t_nc;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    m_s1 = '0; m_s2 = '0; m_db = '0; m_hi = '0; m_lo = '0; m_rst = '0;
    for (int k = 0; k < 4; k++) m_per[k] = 0;
    for (int i = 0; i < NP; i++) m_cnt[i] = 0;
  end

  always @(posedge clk) begin
    if (model_on) begin
      t_db = m_db;
      for (int i = 0; i < NP; i++) begin
        t_c = m_hi[i] * 2 + m_lo[i];
        t_p = (t_c == 0) ? 0 : m_per[t_c];
        if (t_c == 0 || pin_dir[i]) begin
          t_db[i] = m_s2[i];
          t_cnt[i] = t_p;
        end else if (m_rst[i] || (m_s2[i] == m_db[i])) begin
          t_cnt[i] = t_p;
        end else if (m_cnt[i] == 0) begin
          t_db[i] = m_s2[i];
          t_cnt[i] = t_p;
        end else begin
          t_cnt[i] = m_cnt[i] - 1;
        end
      end
      t_hi = m_hi; t_lo = m_lo; t_rst = '0;
      if (reg_wr) begin
        if (reg_addr == 8'h00) t_hi = reg_wdata;
        if (reg_addr == 8'h04) t_lo = reg_wdata;
        for (int i = 0; i < NP; i++) begin
          t_c  = m_hi[i] * 2 + m_lo[i];
          t_nc = t_hi[i] * 2 + t_lo[i];
          if (t_c != t_nc) t_rst[i] = 1'b1;
          if (t_c != 0 && reg_addr == 8'(8'h50 + 4 * (t_c - 1))) t_rst[i] = 1'b1;
        end
        for (int k = 1; k <= 3; k++) begin
          if (reg_addr == 8'(8'h50 + 4 * (k - 1))) m_per[k] = int'(reg_wdata[PW-1:0]);
        end
      end
      m_db = t_db;
      for (int i = 0; i < NP; i++) m_cnt[i] = t_cnt[i];
      m_hi = t_hi; m_lo = t_lo; m_rst = t_rst;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  // Cycle-by-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (model_on && !done) check({cur_req, " model"}, pin_db, m_db);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h10; reg_wdata = '0;
  endtask

  task automatic reg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    reg_addr = 8'h10;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired (R1 run incomplete) got=hung expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h10; reg_wdata = '0;
    pin_dir = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 output in reset", pin_db, '0);
    rst_n = 1'b1;
    wait_n(4);
    model_on = 1'b1;
    // R1: reset state after release
    check("R1 output after release", pin_db, '0);
    reg_check("R1 sel hi reset", 8'h00, '0);
    reg_check("R1 sel lo reset", 8'h04, '0);
    reg_check("R1 timer1 reset", 8'h50, '0);
    reg_check("R1 timer2 reset", 8'h54, '0);
    reg_check("R1 timer3 reset", 8'h58, '0);

    // R2: register map, width truncation, unmapped addresses
    cur_req = "R2";
    reg_write(8'h00, 32'h1234_5678);
    reg_write(8'h04, 32'h9abc_def0);
    reg_write(8'h50, 32'hFFFF_FFFF);
    reg_write(8'h54, 32'h0000_0abc);
    reg_write(8'h58, 32'h7777_0102);
    reg_write(8'h5c, 32'hFFFF_FFFF);
    reg_check("R2 sel hi readback", 8'h00, 32'h1234_5678);
    reg_check("R2 sel lo readback", 8'h04, 32'h9abc_def0);
    reg_check("R2 timer1 truncated", 8'h50, 32'h0000_FFFF);
    reg_check("R2 timer2 readback", 8'h54, 32'h0000_0abc);
    reg_check("R2 timer3 truncated", 8'h58, 32'h0000_0102);
    reg_check("R2 unmapped 0x5c", 8'h5c, '0);
    reg_check("R2 unmapped 0x08", 8'h08, '0);

    // Layout: byte0 code0, byte1 code1 (P=5), byte2 code2 (P=0), byte3 code3 (P=12)
    reg_write(8'h50, 32'd5);
    reg_write(8'h54, 32'd0);
    reg_write(8'h58, 32'd12);
    reg_write(8'h00, 32'hFFFF_0000);
    reg_write(8'h04, 32'hFF00_FF00);
    wait_n(4);

    // R3 R4 R6 R9: one rising step on every pin
    cur_req = "R4";
    pin_in = '1;
    wait_n(2);
    check("R3 nothing after two edges", pin_db, 32'h0000_0000);
    wait_n(1);
    check("R3 R6 bypass and zero period after three edges", pin_db, 32'h00FF_00FF);
    wait_n(4);
    check("R4 timer1 pins still low at edge 7", pin_db, 32'h00FF_00FF);
    wait_n(1);
    check("R4 timer1 pins high at edge 8", pin_db, 32'h00FF_FFFF);
    wait_n(6);
    check("R9 timer3 pins still low at edge 14", pin_db, 32'h00FF_FFFF);
    wait_n(1);
    check("R9 timer3 pins high at edge 15", pin_db, 32'hFFFF_FFFF);
    wait_n(3);

    // R5: short glitch on timer1 pins is rejected, longer one passes
    cur_req = "R5";
    pin_in[15:8] = 8'h00;
    wait_n(4);
    pin_in[15:8] = 8'hFF;
    wait_n(20);
    check("R5 glitch rejected", {24'd0, pin_db[15:8]}, 32'h0000_00FF);
    pin_in[15:8] = 8'h00;
    wait_n(10);
    check("R5 long low accepted", {24'd0, pin_db[15:8]}, 32'h0000_0000);
    pin_in[15:8] = 8'hFF;
    wait_n(12);

    // R7: output-direction pins are never filtered
    cur_req = "R7";
    pin_dir[31:24] = 8'hFF;
    pin_in[31:24] = 8'h00;
    wait_n(3);
    check("R7 output pins follow in three edges", {24'd0, pin_db[31:24]}, 32'h0000_0000);
    pin_in[31:24] = 8'hFF;
    wait_n(3);
    pin_dir = '0;
    wait_n(4);

    // R8: rewriting the pin's timer in mid-count restarts it
    cur_req = "R8";
    pin_in[8] = 1'b0;
    wait_n(4);
    reg_write(8'h50, 32'd20);
    wait_n(4);
    check("R8 not changed at old deadline", {31'd0, pin_db[8]}, 32'd1);
    wait_n(20);
    check("R8 changed after new period", {31'd0, pin_db[8]}, 32'd0);
    // R8: code change restarts as well
    reg_write(8'h50, 32'd5);
    pin_in[9] = 1'b0;
    wait_n(4);
    reg_write(8'h04, 32'hFF00_FC00);
    wait_n(30);
    check("R8 code change settles", {31'd0, pin_db[9]}, 32'd0);

    // R9: mixed random traffic against the reference
    cur_req = "R9";
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      pin_in = pin_in ^ ($urandom & $urandom & $urandom & $urandom & $urandom);
      if (cyc % 97 == 50) begin
        reg_wr = 1'b1;
        case ($urandom % 5)
          0: reg_addr = 8'h00;
          1: reg_addr = 8'h04;
          2: reg_addr = 8'h50;
          3: reg_addr = 8'h54;
          default: reg_addr = 8'h58;
        endcase
        reg_wdata = (reg_addr >= 8'h50) ? ($urandom % 16) : $urandom;
      end else begin
        reg_wr = 1'b0; reg_addr = 8'h10; reg_wdata = '0;
      end
      if (cyc % 811 == 400) pin_dir = $urandom & $urandom;
    end
    @(negedge clk);
    reg_wr = 1'b0;
    wait_n(2);
    done = 1'b1;
    finish_run();
  end

endmodule